// File: doc/BRIEF.md
# Metastability Delay-Tuning Feedback Controller

This block keeps a sampling flip-flop balanced on the edge of metastability. Each cycle where the input strobe is high, it takes the bit that flip-flop captured and moves a saturating up/down counter by one step. A captured one moves the counter down and a captured zero moves it up. Over time the counter settles around the delay setting where both values are equally likely, and it then wanders a few steps either side of that point.

The counter has two fields. The low field steers a fine delay line and the high field steers a coarse one. One fine step is 1/32 of a coarse step, so the whole counter gives one monotonic delay range. Each field is turned into a thermometer enable vector: a larger field value switches on more delay stages. Both tap vectors are registered and change on the same clock edge as the counter.

Top module: `meta_tune_ctrl`

## Requirements
- R1: A synchronous active-high reset loads START_VAL (default 512) into the counter. The tap vectors then show the decoded reset value: coarse bits 0..15 set, fine vector all zero.
- R2: With the strobe high, a captured 1 lowers the counter by one at the next rising edge.
- R3: With the strobe high, a captured 0 raises the counter by one at the next rising edge.
- R4: With the strobe low, the counter and both tap vectors keep their values, whatever the captured bit is.
- R5: At 0, a strobed 1 leaves the counter at 0; it does not wrap.
- R6: At 1023, a strobed 0 leaves the counter at 1023; it does not wrap.
- R7: The fine field is counter bits [4:0]. Fine tap bit k is set exactly when k is less than that field.
- R8: The coarse field is counter bits [9:5]. Coarse tap bit k is set exactly when k is less than that field.
- R9: Both tap vectors update on the same edge as the counter, including a step that carries or borrows across the field boundary.
- R10: Reset takes priority over a strobed bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe that qualifies bit_in |
| bit_in | input | 1 | Bit captured by the metastable flip-flop |
| cnt_o | output | 10 | Current tuning counter |
| fine_tap_o | output | 32 | Thermometer enables for the fine delay stages |
| coarse_tap_o | output | 32 | Thermometer enables for the coarse delay stages |

## Verification
A step where the fine field rolls over (31 to 32, or back) changes both decoders in the same cycle as the counter. The bench forces this with directed single steps around mid-scale, and the random walk crosses the boundary many times. Each step compares the counter and both tap vectors together against values computed from the previous expected count. Saturation meeting a strobed step, and reset meeting a strobe, are provoked at the ends of long directed ramps and by occasional random resets.

// File: rtl/meta_tune_pkg.sv
package meta_tune_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_DN   = 2'd1,
    STEP_UP   = 2'd2
  } step_e;
endpackage

// File: rtl/meta_tune_step.sv
module meta_tune_step #(
  parameter int W     = 10,
  parameter int START = 512
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld,
  input  logic         bit_in,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  import meta_tune_pkg::*;

  localparam logic [W-1:0] START_L = W'(START);
  localparam logic [W-1:0] MAX_L   = {W{1'b1}};

  step_e dir;

  always_comb begin
    if (!vld)       dir = STEP_HOLD;
    else if (bit_in) dir = (cnt_q == '0)    ? STEP_HOLD : STEP_DN;
    else             dir = (cnt_q == MAX_L) ? STEP_HOLD : STEP_UP;
  end

  always_comb begin
    if (rst) cnt_d = START_L;
    else begin
      unique case (dir)
        STEP_DN: cnt_d = cnt_q - W'(1);
        STEP_UP: cnt_d = cnt_q + W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) cnt_q <= cnt_d;
endmodule

// File: rtl/meta_tune_therm.sv
module meta_tune_therm #(
  parameter int FW      = 5,
  parameter bit USE_LUT = 1'b1
) (
  input  logic                clk,
  input  logic [FW-1:0]       field_d,
  output logic [(1<<FW)-1:0]  tap_q
);
  localparam int N = 1 << FW;

  function automatic logic [N-1:0] therm(input int unsigned v);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = (k < v);
    return r;
  endfunction

  generate
    if (USE_LUT) begin : g_lut
      logic [N-1:0] rom [N];
      for (genvar i = 0; i < N; i++) begin : g_row
        assign rom[i] = therm(i);
      end
      always_ff @(posedge clk) tap_q <= rom[field_d];
    end else begin : g_cmp
      always_ff @(posedge clk) tap_q <= therm(int'(field_d));
    end
  endgenerate
endmodule

// File: rtl/meta_tune_ctrl.sv
module meta_tune_ctrl #(
  parameter int CNT_W     = 10,
  parameter int FINE_W    = 5,
  parameter int START_VAL = 512,
  parameter bit DEC_LUT   = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bit_vld,
  input  logic                            bit_in,
  output logic [CNT_W-1:0]                cnt_o,
  output logic [(1<<FINE_W)-1:0]          fine_tap_o,
  output logic [(1<<(CNT_W-FINE_W))-1:0]  coarse_tap_o
);
  localparam int COARSE_W = CNT_W - FINE_W;

  logic [CNT_W-1:0] cnt_d;

  meta_tune_step #(.W(CNT_W), .START(START_VAL)) u_step (
    .clk(clk), .rst(rst), .vld(bit_vld), .bit_in(bit_in),
    .cnt_q(cnt_o), .cnt_d(cnt_d)
  );

  // Decoders read the next-state count so taps move on the counter's edge.
  meta_tune_therm #(.FW(FINE_W), .USE_LUT(DEC_LUT)) u_fine (
    .clk(clk), .field_d(cnt_d[FINE_W-1:0]), .tap_q(fine_tap_o)
  );

  meta_tune_therm #(.FW(COARSE_W), .USE_LUT(DEC_LUT)) u_coarse (
    .clk(clk), .field_d(cnt_d[CNT_W-1:FINE_W]), .tap_q(coarse_tap_o)
  );
endmodule

// File: rtl/meta_tune_ctrl_chk.sv
module meta_tune_ctrl_chk #(
  parameter int CNT_W     = 10,
  parameter int FINE_W    = 5,
  parameter int START_VAL = 512
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            bit_vld,
  input logic                            bit_in,
  input logic [CNT_W-1:0]                cnt_o,
  input logic [(1<<FINE_W)-1:0]          fine_tap_o,
  input logic [(1<<(CNT_W-FINE_W))-1:0]  coarse_tap_o
);
  localparam int FN = 1 << FINE_W;
  localparam int CN = 1 << (CNT_W - FINE_W);
  localparam logic [CNT_W-1:0] MAX_L = {CNT_W{1'b1}};

  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> cnt_o == CNT_W'(START_VAL));

  a_r10_reset_wins: assert property (@(posedge clk)
    rst && bit_vld |=> cnt_o == CNT_W'(START_VAL));

  a_r2_dec: assert property (@(posedge clk) disable iff (rst)
    bit_vld && bit_in && cnt_o != '0 |=> cnt_o == $past(cnt_o) - CNT_W'(1));

  a_r3_inc: assert property (@(posedge clk) disable iff (rst)
    bit_vld && !bit_in && cnt_o != MAX_L |=> cnt_o == $past(cnt_o) + CNT_W'(1));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(cnt_o) && $stable(fine_tap_o) && $stable(coarse_tap_o));

  a_r5_floor: assert property (@(posedge clk) disable iff (rst)
    bit_vld && bit_in && cnt_o == '0 |=> cnt_o == '0);

  a_r6_ceiling: assert property (@(posedge clk) disable iff (rst)
    bit_vld && !bit_in && cnt_o == MAX_L |=> cnt_o == MAX_L);

  a_r7_fine_therm: assert property (@(posedge clk) disable iff (rst)
    $countones(fine_tap_o) == int'(cnt_o[FINE_W-1:0]) &&
    (fine_tap_o & (fine_tap_o + FN'(1))) == '0);

  a_r8_coarse_therm: assert property (@(posedge clk) disable iff (rst)
    $countones(coarse_tap_o) == int'(cnt_o[CNT_W-1:FINE_W]) &&
    (coarse_tap_o & (coarse_tap_o + CN'(1))) == '0);
endmodule

bind meta_tune_ctrl meta_tune_ctrl_chk #(
  .CNT_W(CNT_W), .FINE_W(FINE_W), .START_VAL(START_VAL)
) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
  .cnt_o(cnt_o), .fine_tap_o(fine_tap_o), .coarse_tap_o(coarse_tap_o)
);

// File: tb/meta_tune_ctrl_tb.sv
module meta_tune_ctrl_tb;
  localparam int START = 512;
  localparam int MAXV  = 1023;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_vld = 1'b0;
  logic        bit_in = 1'b0;
  logic [9:0]  cnt_o;
  logic [31:0] fine_tap_o;
  logic [31:0] coarse_tap_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int exp_cnt = START;

  always #5 clk = ~clk;

  meta_tune_ctrl u_dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .cnt_o(cnt_o), .fine_tap_o(fine_tap_o), .coarse_tap_o(coarse_tap_o)
  );

  function automatic logic [31:0] therm_exp(input int v);
    logic [31:0] r = '0;
    for (int k = 0; k < 32; k++) if (k < v) r[k] = 1'b1;
    return r;
  endfunction

  function automatic int model(input int c, input bit r, input bit v, input bit b);
    if (r)  return START;
    if (!v) return c;
    if (b)  return (c == 0) ? 0 : c - 1;
    return (c == MAXV) ? MAXV : c + 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives, waits one rising edge, checks at the next falling edge.
  task automatic step(input bit r, input bit v, input bit b);
    string req;
    if (r && v)      req = "R10";
    else if (r)      req = "R1";
    else if (!v)     req = "R4";
    else if (b)      req = (exp_cnt == 0)    ? "R5" : "R2";
    else             req = (exp_cnt == MAXV) ? "R6" : "R3";
    rst = r; bit_vld = v; bit_in = b;
    @(posedge clk);
    exp_cnt = model(exp_cnt, r, v, b);
    @(negedge clk);
    chk(req, 32'(cnt_o), exp_cnt);
    chk("R7", fine_tap_o, therm_exp(exp_cnt % 32));
    chk("R8", coarse_tap_o, therm_exp(exp_cnt / 32));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(1, 0, 0);
    step(1, 0, 0);
    chk("R1", coarse_tap_o, 32'h0000_FFFF);
    chk("R1", fine_tap_o, 32'h0);
    step(1, 1, 1);
    step(0, 0, 1); step(0, 0, 0); step(0, 0, 1);
    // borrow then carry across the fine/coarse boundary
    step(0, 1, 1);
    chk("R9", coarse_tap_o, therm_exp(15));
    chk("R9", fine_tap_o, 32'h7FFF_FFFF);
    step(0, 1, 0);
    chk("R9", coarse_tap_o, therm_exp(16));
    chk("R9", fine_tap_o, 32'h0);
    for (int i = 0; i < 600; i++) step(0, 1, 1);
    chk("R5", 32'(cnt_o), 0);
    step(0, 0, 0);
    for (int i = 0; i < 1100; i++) step(0, 1, 0);
    chk("R6", 32'(cnt_o), MAXV);
    chk("R8", coarse_tap_o, 32'h7FFF_FFFF);
    step(1, 1, 0);
    // random walk against a bench model of the metastable flip-flop
    for (int i = 0; i < 4000; i++) begin
      bit v, b, r;
      r = ($urandom % 500) == 0;
      v = ($urandom % 4) != 0;
      b = int'($urandom % 1024) < exp_cnt;
      step(r, v, b);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule